// File: doc/BRIEF.md
# Pipeline Operand Bypass Select Unit

This block produces the select lines for the operand bypass multiplexers of a five-stage in-order pipeline. It compares the source register indices held in the Decode, Execute and Memory stages with the destination indices of the older instructions in the Memory and Writeback stages. It qualifies each match with the write-enable and memory-control bits that travel down the pipeline. The multiplexers, the register file and the stall/flush logic are outside the block.

There are three bypass paths. The Execute-stage ALU operands can take the Memory-stage ALU result or the Writeback result. The Memory-stage store data can take a value just loaded by the instruction in Writeback. The Decode-stage register-file reads can take the Writeback value, so that a register file read on the same clock edge as the write still sees the new value. The unit holds no state: every output is a function of the present inputs only.

Top module: `opfwd_unit`

## Requirements
- R1: Each Execute operand select (`ex_sel_a`, `ex_sel_b`) is 2'b00, meaning the register-file value, when its source qualifies against neither producer.
- R2: An Execute operand select is 2'b10, meaning the Memory-stage ALU result, when its source index equals `mem_rd`, `mem_wr_en` is 1 and `mem_rd` is nonzero.
- R3: An Execute operand select is 2'b01, meaning the Writeback result, when its source index equals `wb_rd`, `wb_wr_en` is 1, `wb_rd` is nonzero, and there is no R2 match.
- R4: When a source qualifies against both the Memory and the Writeback producer, the select is 2'b10: the younger producer wins.
- R5: A destination index of 0 never causes any bypass, on any of the five outputs, whatever the control bits are.
- R6: `mem_st_fwd` is 1 exactly when `mem_rs2` equals `wb_rd`, `mem_store` is 1, `wb_load` is 1 and `wb_rd` is nonzero.
- R7: `dec_fwd1` (for `dec_rs1`) and `dec_fwd2` (for `dec_rs2`) are each 1 exactly when that source equals `wb_rd`, `wb_wr_en` is 1 and `wb_rd` is nonzero.
- R8: The two Execute operands are decided independently: the value of one select never depends on the other operand's source index.
- R9: Outputs follow any input change with no clock edge, and the unit keeps no memory of earlier inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | 5 | First source index of the Execute-stage instruction |
| ex_rs2 | input | 5 | Second source index of the Execute-stage instruction |
| mem_rs2 | input | 5 | Store-data source index of the Memory-stage instruction |
| dec_rs1 | input | 5 | First source index of the Decode-stage instruction |
| dec_rs2 | input | 5 | Second source index of the Decode-stage instruction |
| mem_rd | input | 5 | Destination index of the Memory-stage instruction |
| wb_rd | input | 5 | Destination index of the Writeback-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| mem_store | input | 1 | Memory-stage instruction is a store |
| wb_load | input | 1 | Writeback-stage instruction is a load |
| ex_sel_a | output | 2 | First ALU operand select: 00 register, 10 Memory result, 01 Writeback result |
| ex_sel_b | output | 2 | Second ALU operand select, same encoding |
| mem_st_fwd | output | 1 | Store data takes the Writeback load value |
| dec_fwd1 | output | 1 | First Decode read takes the Writeback value |
| dec_fwd2 | output | 1 | Second Decode read takes the Writeback value |

## Verification
A wrong comparison or qualifier shows at once on the select ports, in the same time step as the input that exposes it, because no register stands between input and output. A priority fault appears only when one source matches both producers at the same time, so the stimulus puts identical indices in both stages. A zero-index fault appears only with every write enable set and the indices at zero. The bench models the bypass multiplexers with distinct data values, so a wrong select also shows up as a wrong operand value.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
    localparam int IDX_W = 5;

    typedef enum logic [1:0] {
        OPD_REG = 2'b00,
        OPD_WB  = 2'b01,
        OPD_MEM = 2'b10
    } opd_sel_e;
endpackage

// File: rtl/opfwd_hit.sv
// One qualified index comparison: source equals destination and the
// shared producer qualifier (write enable and nonzero destination) holds.
module opfwd_hit #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic             dst_qual,
    output logic             hit
);
    always_comb begin
        hit = dst_qual && (src_idx == dst_idx);
    end
endmodule

// File: rtl/opfwd_ex_pick.sv
// Priority pick for one Execute operand: the younger Memory producer wins.
module opfwd_ex_pick
    import opfwd_pkg::*;
(
    input  logic     hit_mem,
    input  logic     hit_wb,
    output opd_sel_e sel
);
    always_comb begin
        if (hit_mem)     sel = OPD_MEM;
        else if (hit_wb) sel = OPD_WB;
        else             sel = OPD_REG;
    end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
    import opfwd_pkg::*;
#(
    parameter int RW = IDX_W
) (
    input  logic [RW-1:0] ex_rs1,
    input  logic [RW-1:0] ex_rs2,
    input  logic [RW-1:0] mem_rs2,
    input  logic [RW-1:0] dec_rs1,
    input  logic [RW-1:0] dec_rs2,
    input  logic [RW-1:0] mem_rd,
    input  logic [RW-1:0] wb_rd,
    input  logic          mem_wr_en,
    input  logic          wb_wr_en,
    input  logic          mem_store,
    input  logic          wb_load,
    output logic [1:0]    ex_sel_a,
    output logic [1:0]    ex_sel_b,
    output logic          mem_st_fwd,
    output logic          dec_fwd1,
    output logic          dec_fwd2
);
    localparam int N_EX  = 2;
    localparam int N_DEC = 2;

    // Producer qualifiers, computed once and shared by every comparison.
    logic mem_qual_d;
    logic wb_qual_d;
    logic ld_qual_d;

    always_comb begin
        mem_qual_d = mem_wr_en && (mem_rd != '0);
        wb_qual_d  = wb_wr_en  && (wb_rd  != '0);
        ld_qual_d  = mem_store && wb_load && (wb_rd != '0);
    end

    logic [RW-1:0] ex_src  [N_EX];
    logic [RW-1:0] dec_src [N_DEC];
    opd_sel_e      ex_sel_d [N_EX];
    logic          dec_hit_d [N_DEC];
    logic          st_hit_d;

    always_comb begin
        ex_src[0]  = ex_rs1;
        ex_src[1]  = ex_rs2;
        dec_src[0] = dec_rs1;
        dec_src[1] = dec_rs2;
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_EX; gi++) begin : g_ex
            logic hit_mem_d;
            logic hit_wb_d;

            opfwd_hit #(.IDX_W(RW)) u_hit_mem (
                .src_idx (ex_src[gi]),
                .dst_idx (mem_rd),
                .dst_qual(mem_qual_d),
                .hit     (hit_mem_d)
            );

            opfwd_hit #(.IDX_W(RW)) u_hit_wb (
                .src_idx (ex_src[gi]),
                .dst_idx (wb_rd),
                .dst_qual(wb_qual_d),
                .hit     (hit_wb_d)
            );

            opfwd_ex_pick u_pick (
                .hit_mem(hit_mem_d),
                .hit_wb (hit_wb_d),
                .sel    (ex_sel_d[gi])
            );
        end

        for (gi = 0; gi < N_DEC; gi++) begin : g_dec
            opfwd_hit #(.IDX_W(RW)) u_hit_dec (
                .src_idx (dec_src[gi]),
                .dst_idx (wb_rd),
                .dst_qual(wb_qual_d),
                .hit     (dec_hit_d[gi])
            );
        end
    endgenerate

    opfwd_hit #(.IDX_W(RW)) u_hit_st (
        .src_idx (mem_rs2),
        .dst_idx (wb_rd),
        .dst_qual(ld_qual_d),
        .hit     (st_hit_d)
    );

    always_comb begin
        ex_sel_a   = ex_sel_d[0];
        ex_sel_b   = ex_sel_d[1];
        mem_st_fwd = st_hit_d;
        dec_fwd1   = dec_hit_d[0];
        dec_fwd2   = dec_hit_d[1];
    end
endmodule

// File: rtl/opfwd_unit_chk.sv
module opfwd_unit_chk #(
    parameter int RW = 5
) (
    input logic [RW-1:0] ex_rs1,
    input logic [RW-1:0] ex_rs2,
    input logic [RW-1:0] mem_rs2,
    input logic [RW-1:0] dec_rs1,
    input logic [RW-1:0] dec_rs2,
    input logic [RW-1:0] mem_rd,
    input logic [RW-1:0] wb_rd,
    input logic          mem_wr_en,
    input logic          wb_wr_en,
    input logic          mem_store,
    input logic          wb_load,
    input logic [1:0]    ex_sel_a,
    input logic [1:0]    ex_sel_b,
    input logic          mem_st_fwd,
    input logic          dec_fwd1,
    input logic          dec_fwd2
);
    always_comb begin
        // R1
        sel_code_legal_chk: assert (ex_sel_a != 2'b11 && ex_sel_b != 2'b11)
            else $error("illegal operand select");
        // R2
        mem_pick_cause_chk: assert (ex_sel_a != 2'b10 ||
                                    (mem_wr_en && mem_rd != '0 && ex_rs1 == mem_rd))
            else $error("Memory bypass without qualified match");
        // R4
        mem_over_wb_chk: assert (!(mem_wr_en && mem_rd != '0 && ex_rs2 == mem_rd) ||
                                 ex_sel_b == 2'b10)
            else $error("Memory producer lost priority");
        // R3
        wb_pick_cause_chk: assert (ex_sel_b != 2'b01 ||
                                   (wb_wr_en && wb_rd != '0 && ex_rs2 == wb_rd))
            else $error("Writeback bypass without qualified match");
        // R5
        zero_dst_chk: assert (wb_rd != '0 || !(mem_st_fwd || dec_fwd1 || dec_fwd2))
            else $error("bypass from index zero");
        // R6
        store_copy_chk: assert (!mem_st_fwd || (mem_store && wb_load && mem_rs2 == wb_rd))
            else $error("store bypass without load producer");
        // R7
        dec_read_chk: assert (!dec_fwd2 || (wb_wr_en && dec_rs2 == wb_rd))
            else $error("decode bypass without Writeback write");
    end
endmodule

bind opfwd_unit opfwd_unit_chk #(.RW(RW)) u_opfwd_unit_chk (.*);

// File: tb/opfwd_unit_bench.sv
module opfwd_unit_bench;
    localparam int  NV   = 12;
    localparam real TCLK = 8.0;

    logic clk = 1'b0;
    always #(TCLK / 2) clk = ~clk;

    logic [4:0] ex_rs1, ex_rs2, mem_rs2, dec_rs1, dec_rs2, mem_rd, wb_rd;
    logic       mem_wr_en, wb_wr_en, mem_store, wb_load;
    logic [1:0] ex_sel_a, ex_sel_b;
    logic       mem_st_fwd, dec_fwd1, dec_fwd2;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    opfwd_unit u_opfwd_unit (
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .mem_rs2(mem_rs2),
        .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
        .mem_rd(mem_rd), .wb_rd(wb_rd),
        .mem_wr_en(mem_wr_en), .wb_wr_en(wb_wr_en),
        .mem_store(mem_store), .wb_load(wb_load),
        .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
        .mem_st_fwd(mem_st_fwd), .dec_fwd1(dec_fwd1), .dec_fwd2(dec_fwd2)
    );

    // {ex_rs1, ex_rs2, mem_rs2, dec_rs1, dec_rs2, mem_rd, wb_rd,
    //  mem_wr_en, wb_wr_en, mem_store, wb_load,
    //  sel_a, sel_b, st_fwd, fwd1, fwd2}
    localparam logic [45:0] VECS [NV] = '{
        // R1 R5: all zero
        {5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 4'b0000, 2'b00, 2'b00, 3'b000},
        // R2 R8: rs1 hits Memory, rs2 untouched
        {5'd3, 5'd4, 5'd0, 5'd0, 5'd0, 5'd3, 5'd0, 4'b1000, 2'b10, 2'b00, 3'b000},
        // R3 R8: rs2 hits Writeback
        {5'd5, 5'd6, 5'd0, 5'd0, 5'd0, 5'd0, 5'd6, 4'b0100, 2'b00, 2'b01, 3'b000},
        // R4: both producers match, Memory wins
        {5'd7, 5'd7, 5'd0, 5'd0, 5'd0, 5'd7, 5'd7, 4'b1100, 2'b10, 2'b10, 3'b000},
        // R1: indices match but write enables low
        {5'd3, 5'd9, 5'd0, 5'd0, 5'd0, 5'd3, 5'd9, 4'b0000, 2'b00, 2'b00, 3'b000},
        // R5: index zero everywhere with every control bit set
        {5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 4'b1111, 2'b00, 2'b00, 3'b000},
        // R6: load then store copy
        {5'd1, 5'd2, 5'd8, 5'd0, 5'd0, 5'd0, 5'd8, 4'b0111, 2'b00, 2'b00, 3'b100},
        // R6: no load in Writeback, no copy
        {5'd1, 5'd2, 5'd8, 5'd0, 5'd0, 5'd0, 5'd8, 4'b0110, 2'b00, 2'b00, 3'b000},
        // R7: first Decode read only
        {5'd0, 5'd0, 5'd0, 5'd10, 5'd11, 5'd0, 5'd10, 4'b0100, 2'b00, 2'b00, 3'b010},
        // R7: both Decode reads
        {5'd0, 5'd0, 5'd0, 5'd12, 5'd12, 5'd0, 5'd12, 4'b0100, 2'b00, 2'b00, 3'b011},
        // R7: Writeback not writing
        {5'd0, 5'd0, 5'd0, 5'd12, 5'd12, 5'd0, 5'd12, 4'b0000, 2'b00, 2'b00, 3'b000},
        // R8: crossed operands, R7 alongside
        {5'd20, 5'd21, 5'd0, 5'd20, 5'd0, 5'd21, 5'd20, 4'b1100, 2'b01, 2'b10, 3'b010}
    };

    task automatic chk(input string req, input logic [6:0] got, input logic [6:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    function automatic logic [6:0] outs();
        return {ex_sel_a, ex_sel_b, mem_st_fwd, dec_fwd1, dec_fwd2};
    endfunction

    // Bench model of the first ALU operand multiplexer.
    function automatic logic [31:0] opnd_a(input logic [1:0] s);
        case (s)
            2'b10:   return 32'hA000_0001;
            2'b01:   return 32'hB000_0002;
            default: return 32'hC000_0003;
        endcase
    endfunction

    initial begin : watchdog
        #(TCLK * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        {ex_rs1, ex_rs2, mem_rs2, dec_rs1, dec_rs2, mem_rd, wb_rd,
         mem_wr_en, wb_wr_en, mem_store, wb_load} = '0;
        @(negedge clk);
        chk("R1 idle", outs(), 7'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {ex_rs1, ex_rs2, mem_rs2, dec_rs1, dec_rs2, mem_rd, wb_rd,
             mem_wr_en, wb_wr_en, mem_store, wb_load} = VECS[i][45:7];
            #1;
            chk($sformatf("R1-vec%0d", i), outs(), VECS[i][6:0]);
        end

        // R2 R3 R4: sweep rs1 against fixed producers 17 (Memory) and 9 (Writeback)
        for (int s = 0; s < 32; s++) begin
            logic [1:0] e;
            @(negedge clk);
            {ex_rs1, ex_rs2, mem_rs2, dec_rs1, dec_rs2} = {5'(s), 5'd0, 5'd0, 5'd0, 5'd0};
            mem_rd = 5'd17; wb_rd = 5'd9;
            {mem_wr_en, wb_wr_en, mem_store, wb_load} = 4'b1100;
            e = (s == 17) ? 2'b10 : (s == 9) ? 2'b01 : 2'b00;
            #1;
            chk("R2 R3 sweep", {5'b0, ex_sel_a}, {5'b0, e});
            chk("R2 mux model", {5'b0, opnd_a(ex_sel_a) == opnd_a(e)}, 7'b1);
        end

        // R9: change an input between clock edges, output follows without an edge
        @(negedge clk);
        {ex_rs1, ex_rs2, mem_rs2, dec_rs1, dec_rs2, mem_rd, wb_rd} =
            {5'd4, 5'd0, 5'd0, 5'd0, 5'd0, 5'd4, 5'd0};
        {mem_wr_en, wb_wr_en, mem_store, wb_load} = 4'b1000;
        #1;
        chk("R9 before", {5'b0, ex_sel_a}, 7'b10);
        mem_rd = 5'd5;
        #1;
        chk("R9 no memory", {5'b0, ex_sel_a}, 7'b00);
        mem_rd = 5'd4;
        #1;
        chk("R9 return", {5'b0, ex_sel_a}, 7'b10);

        // R5: Memory destination zero with source zero and write set
        ex_rs2 = 5'd0; mem_rd = 5'd0; ex_rs1 = 5'd0;
        #1;
        chk("R5 mem zero", outs(), 7'b0);

        // R8: second operand source change leaves first select alone
        mem_rd = 5'd4; ex_rs1 = 5'd4; ex_rs2 = 5'd4;
        #1;
        chk("R8 both", outs(), {2'b10, 2'b10, 3'b000});
        ex_rs2 = 5'd6;
        #1;
        chk("R8 split", outs(), {2'b10, 2'b00, 3'b000});

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule